// File: doc/BRIEF.md
# Ordered Write Buffer with Fences

The block sits between a processor core and a memory bus and holds pending memory writes. The core hands ordinary stores (address, data, byte enables) to a four-entry circular queue and continues at once. The queue drains the stores to a memory port that has only one transaction outstanding, strictly in the order they were accepted. A store counts as accepted when it enters the queue, not when the bus finishes it.

Loads from the core may reach memory ahead of older buffered stores. A load whose word address matches a buffered store is answered from the youngest matching entry when that entry's byte enables cover every requested byte. When the match does not cover the load, the load stalls until the matching stores have drained.

A write flagged as I/O never enters the queue. It waits until the queue is empty, goes straight to the memory port, and is acknowledged only when its response returns. A fence request (used for locked or serialising operations) is acknowledged only while the queue is empty. While a fence or an I/O write is waiting, the port sends buffered stores ahead of loads.

Top module: `ord_wbuf`

## Requirements
- R1: While rst_ni is low, mem_req_o is 0, fence_ack_o is 0, and st_ready_o is 1 for an ordinary store, because the queue is empty.
- R2: For an ordinary store (st_io_i=0), st_ready_o is 1 exactly when fewer than 4 stores are buffered. A store is accepted when st_valid_i and st_ready_o are both high at a rising edge, without waiting for memory.
- R3: Buffered stores appear on the memory port with mem_we_o=1 in acceptance order, carrying their own address, data and byte enables. An entry leaves the queue when mem_rsp_i completes its transaction.
- R4: A memory transaction completes on a rising edge where mem_req_o and mem_rsp_i are both high. Until then mem_req_o stays high and mem_we_o, mem_addr_o, mem_wdata_o and mem_be_o hold their values.
- R5: A load that matches no buffered entry is sent to memory with mem_we_o=0. When no fence or I/O write is waiting, it goes ahead of older buffered stores. ld_ready_o is high in the cycle of its response, with ld_data_o equal to mem_rdata_i.
- R6: Word match means equal address bits [31:2]. When the youngest matching entry's byte enables cover all set bits of ld_be_i, ld_ready_o is high in the same cycle with that entry's data, and no memory read is issued.
- R7: When the youngest match does not cover the load, ld_ready_o stays low and no read is issued until no matching entry remains. The load is then read from memory.
- R8: An I/O write (st_io_i=1) is never buffered. It is issued to memory only while the queue is empty, and st_ready_o rises only in the cycle of its memory response.
- R9: fence_ack_o is 1 exactly when fence_req_i is 1 and the queue is empty.
- R10: While fence_req_i is high, or an I/O write is waiting, a free memory port issues the head store before any load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Core write request |
| st_io_i | input | 1 | Write is an uncached I/O write |
| st_addr_i | input | 32 | Write byte address |
| st_data_i | input | 32 | Write data |
| st_be_i | input | 4 | Write byte enables |
| st_ready_o | output | 1 | Store accepted, or I/O write completed |
| ld_valid_i | input | 1 | Core load request |
| ld_addr_i | input | 32 | Load byte address |
| ld_be_i | input | 4 | Requested bytes |
| ld_ready_o | output | 1 | Load data valid this cycle |
| ld_data_o | output | 32 | Load data |
| fence_req_i | input | 1 | Fence, locked or serialising request |
| fence_ack_o | output | 1 | All buffered stores completed |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory byte enables |
| mem_rsp_i | input | 1 | Memory response, completes current request |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The assertions check the following on every cycle:
- Request fields hold steady until the response (R4).
- The queue never overflows.
- An I/O write never grows the queue and is acknowledged only on an empty queue.
- A forwarded load starts no read.
- A waiting fence or I/O write makes a free port pick the head store.

Some behaviours need the bench's scenarios and its reference queue:
- Stores reaching memory in acceptance order with intact fields.
- Forwarding picking the youngest of two matching entries.
- A partially covered load waiting for the drain.
- A load actually overtaking two queued stores when nothing drains, and waiting behind them when something does.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  parameter int unsigned AW = 32;
  parameter int unsigned DW = 32;
  localparam int unsigned BW = DW / 8;
  localparam int unsigned OFS = $clog2(BW);
  localparam int unsigned WAW = AW - OFS;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [BW-1:0] be;
  } wb_ent_t;

  typedef enum logic [1:0] {TK_ST, TK_LD, TK_IO} txn_e;
endpackage

// File: rtl/wbuf_queue.sv
module wbuf_queue
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  wb_ent_t        push_ent_i,
  input  logic           pop_i,
  input  logic [WAW-1:0] ld_waddr_i,
  output wb_ent_t        head_o,
  output logic           empty_o,
  output logic           full_o,
  output logic           hit_o,
  output wb_ent_t        hit_ent_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  wb_ent_t        mem_q [DEPTH];
  logic [PW-1:0]  rd_q, wr_q;
  logic [CW-1:0]  cnt_q;
  logic [DEPTH-1:0] match;
  logic [PW-1:0]  age [DEPTH];

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_ent_i;
  end

  // per-slot age relative to head and word-address compare
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign age[g]   = PW'(g) - rd_q;
    assign match[g] = (CW'(age[g]) < cnt_q) &&
                      (mem_q[g].addr[AW-1:OFS] == ld_waddr_i);
  end

  // youngest match = largest age
  always_comb begin
    logic [PW-1:0] best;
    hit_o     = 1'b0;
    hit_ent_o = '0;
    best      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && (!hit_o || age[i] > best)) begin
        hit_o     = 1'b1;
        best      = age[i];
        hit_ent_o = mem_q[i];
      end
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  // R3
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/wbuf_port.sv
module wbuf_port
  import wbuf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drain_i,
  input  logic          ld_req_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [BW-1:0] ld_be_i,
  input  logic          st_req_i,
  input  wb_ent_t       st_ent_i,
  input  logic          io_req_i,
  input  wb_ent_t       io_ent_i,
  input  logic          mem_rsp_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [BW-1:0] mem_be_o,
  output logic          done_o,
  output txn_e          kind_o
);
  logic    busy_q;
  txn_e    kind_q;
  wb_ent_t ent_q;
  logic    pick_v;
  txn_e    pick_k;
  wb_ent_t pick_e, ld_ent;

  assign ld_ent = '{addr: ld_addr_i, data: '0, be: ld_be_i};

  always_comb begin
    pick_v = 1'b1;
    pick_k = TK_LD;
    pick_e = ld_ent;
    if (drain_i) begin
      if (st_req_i)      begin pick_k = TK_ST; pick_e = st_ent_i; end
      else if (io_req_i) begin pick_k = TK_IO; pick_e = io_ent_i; end
      else               pick_v = ld_req_i;
    end else begin
      if (ld_req_i)      pick_k = TK_LD;
      else if (st_req_i) begin pick_k = TK_ST; pick_e = st_ent_i; end
      else if (io_req_i) begin pick_k = TK_IO; pick_e = io_ent_i; end
      else               pick_v = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= TK_ST;
      ent_q  <= '0;
    end else if (busy_q) begin
      if (mem_rsp_i) busy_q <= 1'b0;
    end else if (pick_v) begin
      busy_q <= 1'b1;
      kind_q <= pick_k;
      ent_q  <= pick_e;
    end
  end

  assign mem_req_o   = busy_q;
  assign mem_we_o    = (kind_q != TK_LD);
  assign mem_addr_o  = ent_q.addr;
  assign mem_wdata_o = ent_q.data;
  assign mem_be_o    = ent_q.be;
  assign done_o      = busy_q && mem_rsp_i;
  assign kind_o      = kind_q;

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_wdata_o) && $stable(mem_be_o) && $stable(mem_we_o)));
  // R10
  drain_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && drain_i && st_req_i) |=> (mem_req_o && kind_q == TK_ST));
endmodule

// File: rtl/ord_wbuf.sv
module ord_wbuf
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  input  logic          st_io_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [BW-1:0] st_be_i,
  output logic          st_ready_o,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [BW-1:0] ld_be_i,
  output logic          ld_ready_o,
  output logic [DW-1:0] ld_data_o,
  input  logic          fence_req_i,
  output logic          fence_ack_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [BW-1:0] mem_be_o,
  input  logic          mem_rsp_i,
  input  logic [DW-1:0] mem_rdata_i
);
  wb_ent_t st_ent, head, hit_ent;
  logic    q_empty, q_full, hit, push, pop, fwd_ok, drain, io_req, done;
  txn_e    kind;

  assign st_ent = '{addr: st_addr_i, data: st_data_i, be: st_be_i};
  assign drain  = fence_req_i || (st_valid_i && st_io_i);
  assign push   = st_valid_i && !st_io_i && !q_full;
  assign pop    = done && (kind == TK_ST);
  assign io_req = st_valid_i && st_io_i && q_empty;
  assign fwd_ok = ld_valid_i && hit && ((hit_ent.be & ld_be_i) == ld_be_i);

  wbuf_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_ent_i (st_ent),
    .pop_i      (pop),
    .ld_waddr_i (ld_addr_i[AW-1:OFS]),
    .head_o     (head),
    .empty_o    (q_empty),
    .full_o     (q_full),
    .hit_o      (hit),
    .hit_ent_o  (hit_ent)
  );

  wbuf_port u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drain_i     (drain),
    .ld_req_i    (ld_valid_i && !hit),
    .ld_addr_i   (ld_addr_i),
    .ld_be_i     (ld_be_i),
    .st_req_i    (!q_empty),
    .st_ent_i    (head),
    .io_req_i    (io_req),
    .io_ent_i    (st_ent),
    .mem_rsp_i   (mem_rsp_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_be_o    (mem_be_o),
    .done_o      (done),
    .kind_o      (kind)
  );

  assign st_ready_o  = st_io_i ? (done && kind == TK_IO) : !q_full;
  assign ld_ready_o  = fwd_ok || (done && kind == TK_LD);
  assign ld_data_o   = fwd_ok ? hit_ent.data : mem_rdata_i;
  assign fence_ack_o = fence_req_i && q_empty;

  // R8
  io_unbuffered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && st_io_i) |=> !(q_full && !$past(q_full)));
  // R8
  io_ack_drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && st_io_i && st_ready_o) |-> (q_empty && mem_we_o));
  // R9
  fence_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_ack_o |-> !(mem_req_o && kind == TK_ST));
  // R6
  fwd_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_ok && !(mem_req_o && !mem_we_o)) |=> !(mem_req_o && !mem_we_o));
endmodule

// File: tb/ord_wbuf_bench.sv
module ord_wbuf_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, st_io = 0, ld_valid = 0, fence_req = 0, mem_rsp = 0;
  logic [31:0] st_addr = 0, st_data = 0, ld_addr = 0, mem_rdata;
  logic [3:0]  st_be = 0, ld_be = 0;
  logic st_ready, ld_ready, fence_ack, mem_req, mem_we;
  logic [31:0] ld_data, mem_addr, mem_wdata;
  logic [3:0]  mem_be;

  always #2 clk = ~clk; // 250 MHz

  ord_wbuf u_ord_wbuf (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_io_i(st_io), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_be_i(st_be), .st_ready_o(st_ready),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_be_i(ld_be),
    .ld_ready_o(ld_ready), .ld_data_o(ld_data),
    .fence_req_i(fence_req), .fence_ack_o(fence_ack),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .mem_rsp_i(mem_rsp), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] rd_val(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5a5a_0f0f;
  endfunction
  assign mem_rdata = rd_val(mem_addr);

  typedef struct {logic [31:0] a; logic [31:0] d; logic [3:0] b;} st_t;
  st_t mq[$];
  int n_cmp = 0, n_bad = 0, n_wr = 0, lat = 2, wcnt = 0, ld_done_q = -1;
  logic p_req = 0, p_rsp = 0, p_we = 0;
  logic [31:0] p_addr = 0, p_wdata = 0;
  logic [3:0]  p_be = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // memory responder
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin mem_rsp = 0; wcnt = 0; end
    else if (mem_rsp) mem_rsp = 0;
    else if (mem_req) begin
      if (wcnt >= lat) begin mem_rsp = 1; wcnt = 0; end
      else wcnt++;
    end
  end

  // reference model, compared every clock
  always @(negedge clk) begin
    if (rst_n) begin
      bit cmpl, fhit, cov, can_push;
      int fi;
      cmpl = mem_req && mem_rsp;
      fhit = 0; fi = 0;
      foreach (mq[i]) if (mq[i].a[31:2] == ld_addr[31:2]) begin fhit = 1; fi = i; end
      cov = fhit && ((mq[fi].b & ld_be) == ld_be);
      if (ld_valid) begin
        if (cov) chk(ld_ready && ld_data == mq[fi].d, "R6 forward", ld_data, mq[fi].d);
        else if (fhit) chk(!ld_ready, "R7 stall", ld_ready, 0);
        else begin
          chk(ld_ready == (cmpl && !mem_we), "R5 load ready", ld_ready, cmpl && !mem_we);
          if (ld_ready) chk(ld_data == rd_val(ld_addr), "R5 load data", ld_data, rd_val(ld_addr));
        end
      end
      if (st_valid && !st_io) chk(st_ready == (mq.size() < 4), "R2 ready", st_ready, mq.size() < 4);
      if (st_valid && st_io)
        chk(st_ready == (cmpl && mem_we && mq.size() == 0), "R8 io ack", st_ready, 0);
      chk(fence_ack == (fence_req && mq.size() == 0), "R9 fence", fence_ack, mq.size());
      if (p_req && !p_rsp)
        chk(mem_req && mem_addr == p_addr && mem_wdata == p_wdata && mem_be == p_be
            && mem_we == p_we, "R4 hold", mem_addr, p_addr);
      if (cmpl) begin
        if (mem_we) begin
          n_wr++;
          if (mq.size() > 0)
            chk(mem_addr == mq[0].a && mem_wdata == mq[0].d && mem_be == mq[0].b,
                "R3 order", mem_wdata, mq[0].d);
          else
            chk(st_valid && st_io && mem_addr == st_addr && mem_wdata == st_data,
                "R8 io write", mem_addr, st_addr);
        end else begin
          bit m;
          m = 0;
          foreach (mq[i]) if (mq[i].a[31:2] == mem_addr[31:2]) m = 1;
          chk(!m, "R7 read past match", m, 0);
          chk(ld_valid && mem_addr == ld_addr, "R5 read addr", mem_addr, ld_addr);
          ld_done_q = mq.size();
        end
      end
      can_push = st_valid && !st_io && mq.size() < 4;
      if (cmpl && mem_we && mq.size() > 0) void'(mq.pop_front());
      if (can_push) mq.push_back('{st_addr, st_data, st_be});
      p_req = mem_req; p_rsp = mem_rsp; p_addr = mem_addr;
      p_wdata = mem_wdata; p_be = mem_be; p_we = mem_we;
    end
  end

  task automatic do_store(input logic [31:0] a, d, input logic [3:0] b, input bit io);
    @(posedge clk); #1;
    st_valid = 1; st_io = io; st_addr = a; st_data = d; st_be = b;
    do @(negedge clk); while (!st_ready);
    @(posedge clk); #1;
    st_valid = 0; st_io = 0;
  endtask

  task automatic do_load(input logic [31:0] a, input logic [3:0] b);
    @(posedge clk); #1;
    ld_valid = 1; ld_addr = a; ld_be = b;
    do @(negedge clk); while (!ld_ready);
    @(posedge clk); #1;
    ld_valid = 0;
  endtask

  task automatic do_fence();
    @(posedge clk); #1;
    fence_req = 1;
    do @(negedge clk); while (!fence_ack);
    @(posedge clk); #1;
    fence_req = 0;
  endtask

  task automatic run_all();
    int w0;
    repeat (3) begin
      @(negedge clk);
      chk(!mem_req && !fence_ack && st_ready, "R1 reset", {mem_req, fence_ack, st_ready}, 3'b001);
    end
    @(posedge clk); #1 rst_n = 1;

    // R2/R3: fill beyond depth, then drain
    lat = 3;
    for (int i = 0; i < 6; i++) do_store(32'h100 + 4 * i, 32'hA000 + i, 4'hF, 0);
    do_fence();

    // R5: load overtakes two queued stores
    lat = 4;
    for (int i = 0; i < 3; i++) do_store(32'h180 + 4 * i, 32'hB000 + i, 4'hF, 0);
    ld_done_q = -1;
    do_load(32'h200, 4'hF);
    chk(ld_done_q == 2, "R5 bypass", ld_done_q, 2);
    do_fence();

    // R10: fence pending, load waits behind stores
    for (int i = 0; i < 3; i++) do_store(32'h1c0 + 4 * i, 32'hC000 + i, 4'hF, 0);
    ld_done_q = -1;
    fork do_fence(); do_load(32'h240, 4'h3); join
    chk(ld_done_q == 0, "R10 drain first", ld_done_q, 0);

    // R6: youngest covering match forwarded
    lat = 6;
    do_store(32'h300, 32'h1111_1111, 4'hF, 0);
    do_store(32'h302, 32'h2222_2222, 4'hF, 0);
    do_load(32'h301, 4'h4);
    do_fence();

    // R7: partial cover stalls until drained
    do_store(32'h400, 32'h3333_3333, 4'h3, 0);
    ld_done_q = -1;
    do_load(32'h400, 4'hC);
    chk(ld_done_q == 0, "R7 after drain", ld_done_q, 0);

    // R8: I/O write after two stores
    lat = 2;
    w0 = n_wr;
    do_store(32'h500, 32'h55, 4'hF, 0);
    do_store(32'h504, 32'h66, 4'hF, 0);
    do_store(32'h900, 32'h77, 4'hF, 1);
    chk(n_wr == w0 + 3 && mq.size() == 0, "R8 io count", n_wr - w0, 3);
    do_fence();

    // mixed traffic
    for (int k = 0; k < 60; k++) begin
      int op;
      logic [31:0] a;
      op = $urandom % 4;
      lat = $urandom % 4;
      a = 32'h600 + 4 * ($urandom % 6);
      case (op)
        0, 1: do_store(a, $urandom, 4'($urandom % 15 + 1), 0);
        2: do_load(a, 4'($urandom % 15 + 1));
        default: do_fence();
      endcase
    end
    do_fence();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog R1 to R10 act=hung exp=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule